// File: doc/BRIEF.md
# Packed-Word Channel Access Control Updater

This block advances a 36-bit access control word each time one character moves on a multiplexed channel whose devices each own their own control word. A channel carries either 18-bit half-words or 9-bit quarter-words, chosen by a static mode input. The control word holds a position field, a remaining count, an address step code and a word address. The position field walks through the sub-word lanes of the addressed storage word. Only when the last lane has been used does the block decrement the count and step the address.

On each transfer strobe the block registers the updated control word and the lane that the transfer used. It also registers one-cycle flags: the word address was stepped, a monitor interrupt is requested, end of transmission is requested, the terminal count was reached, or the transfer was refused. A chaining or tabling controller outside the block consumes these flags. Storage access and absolute address formation are done elsewhere.

Top module: `chan_acw_stepper`

## Requirements
- R1: Half-word layout: step code in bits 35-34, position in bit 33, count in bits 32-18, address in bits 17-0. A half-word transfer with position 0 sets the position to 1 and leaves the count and the address unchanged.
- R2: A half-word transfer with position 1 clears the position, decrements the count and steps the address.
- R3: The step code sets the address change when a word completes: 00 adds one, 10 subtracts one, 01 and 11 leave it unchanged. The 18-bit address wraps.
- R4: Quarter-word layout: step code in bits 35-34, position in bits 33-32, control bits in 31-30, count in 29-18, address in 17-0. The position increments on each transfer. Only the step from 11 to 00 decrements the count and steps the address; the control bits are carried through unchanged.
- R5: `lane_sel` gives the input position. In quarter mode, 0, 1, 2 and 3 mean bits 35-27, 26-18, 17-9 and 8-0. In half mode, 0 means bits 17-0 and 1 means bits 35-18.
- R6: When a completing transfer takes the count from 1 to 0, `mon_irq` and `term_pulse` are raised.
- R7: In quarter mode on an output transfer, bit 30 set also raises `mon_irq` when a completing transfer takes the count from 2 to 1.
- R8: In quarter mode on an output transfer, bit 31 set raises `eot_req` when a completing transfer takes the count from 2 to 1. `eot_req` is never raised otherwise.
- R9: The bits 31-30 have no effect on input transfers.
- R10: A transfer with a count of 0 is refused. `refuse_err` is raised, `acw_out` equals the input word, and no other flag is raised.
- R11: Outputs are registered one cycle after `xfer_go`. Every flag is a one-cycle pulse, and all outputs are zero after reset.
- R12: `word_step` is raised exactly when an accepted transfer uses the last lane of its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quarter_mode | input | 1 | 1 = 9-bit lanes, 0 = 18-bit lanes |
| is_output | input | 1 | 1 = output transfer, 0 = input |
| xfer_go | input | 1 | One character transferred this cycle |
| acw_in | input | 36 | Current control word |
| acw_out | output | 36 | Updated control word |
| lane_sel | output | 2 | Lane used by the transfer |
| word_step | output | 1 | Last lane used; count and address stepped |
| mon_irq | output | 1 | Monitor interrupt request |
| eot_req | output | 1 | End-of-transmission request |
| term_pulse | output | 1 | Count reached zero |
| refuse_err | output | 1 | Transfer refused, count already zero |

## Verification
The bench targets the count edges. It checks the count at 1 and 2 on completing and on non-completing lanes, because a design that tested the count without the last-lane condition would raise early requests in mid-word. It wraps the address at both ends, so a design with a swapped step code would move the address the wrong way. It sets the control bits on an input transfer, and a design that ignored the direction would raise end of transmission there. It presents a zero count, and a design that did not refuse it would wrap the count to all ones.

// File: rtl/chan_acw_stepper.sv
module chan_acw_stepper #(
  parameter int ADDR_W = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        quarter_mode,
  input  logic        is_output,
  input  logic        xfer_go,
  input  logic [35:0] acw_in,
  output logic [35:0] acw_out,
  output logic [1:0]  lane_sel,
  output logic        word_step,
  output logic        mon_irq,
  output logic        eot_req,
  output logic        term_pulse,
  output logic        refuse_err
);
  localparam int HW_W = 33 - ADDR_W;
  localparam int QW_W = 30 - ADDR_W;

  logic [1:0]        step;
  logic [ADDR_W-1:0] addr, addr_nx;
  logic [HW_W-1:0]   cnt_h;
  logic [QW_W-1:0]   cnt_q;
  logic [HW_W-1:0]   cnt;
  logic [1:0]        pos_q, ctl;
  logic              pos_h, last, empty, early;
  logic [35:0]       acw_nx;
  logic [1:0]        lane_nx;

  assign step  = acw_in[35:34];
  assign addr  = acw_in[ADDR_W-1:0];
  assign cnt_h = acw_in[32:18];
  assign cnt_q = acw_in[29:18];
  assign pos_h = acw_in[33];
  assign pos_q = acw_in[33:32];
  assign ctl   = acw_in[31:30];
  assign cnt   = quarter_mode ? HW_W'(cnt_q) : cnt_h;
  assign last  = quarter_mode ? (pos_q == 2'b11) : pos_h;
  assign empty = (cnt == '0);
  assign lane_nx = quarter_mode ? pos_q : {1'b0, pos_h};
  assign early = quarter_mode && is_output && last && (cnt == HW_W'(2));

  always_comb begin
    case (step)
      2'b00:   addr_nx = addr + 1'b1;
      2'b10:   addr_nx = addr - 1'b1;
      default: addr_nx = addr;
    endcase
  end

  always_comb begin
    if (empty)
      acw_nx = acw_in;
    else if (quarter_mode)
      acw_nx = last ? {step, 2'b00, ctl, cnt_q - 1'b1, addr_nx}
                    : {step, pos_q + 2'b01, ctl, cnt_q, addr};
    else
      acw_nx = last ? {step, 1'b0, cnt_h - 1'b1, addr_nx}
                    : {step, 1'b1, cnt_h, addr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acw_out    <= '0;
      lane_sel   <= '0;
      word_step  <= 1'b0;
      mon_irq    <= 1'b0;
      eot_req    <= 1'b0;
      term_pulse <= 1'b0;
      refuse_err <= 1'b0;
    end else begin
      word_step  <= 1'b0;
      mon_irq    <= 1'b0;
      eot_req    <= 1'b0;
      term_pulse <= 1'b0;
      refuse_err <= 1'b0;
      if (xfer_go) begin
        acw_out    <= acw_nx;
        lane_sel   <= lane_nx;
        refuse_err <= empty;
        word_step  <= last && !empty;
        term_pulse <= last && (cnt == HW_W'(1));
        mon_irq    <= (last && (cnt == HW_W'(1))) || (early && ctl[0]);
        eot_req    <= early && ctl[1];
      end
    end
  end

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_go |=> !(word_step || mon_irq || eot_req || term_pulse || refuse_err));
  a_r10_refuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_err |-> (acw_out == $past(acw_in)) && !(word_step || mon_irq || eot_req || term_pulse));
  a_r6_term_has_mon: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |-> mon_irq && word_step);
  a_r8_eot_quarter_out: assert property (@(posedge clk) disable iff (!rst_n)
    eot_req |-> $past(quarter_mode) && $past(is_output) && word_step);
  a_r12_step_clears_pos: assert property (@(posedge clk) disable iff (!rst_n)
    word_step && !$past(quarter_mode) |-> !acw_out[33] && $past(acw_in[33]));
  a_r4_quarter_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    word_step && $past(quarter_mode) |-> acw_out[33:32] == 2'b00 && acw_out[31:30] == $past(acw_in[31:30]));
endmodule

// File: tb/chan_acw_stepper_bench.sv
module chan_acw_stepper_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, quarter_mode, is_output, xfer_go;
  logic [35:0] acw_in, acw_out;
  logic [1:0] lane_sel;
  logic word_step, mon_irq, eot_req, term_pulse, refuse_err;
  int errors = 0, checks = 0;

  chan_acw_stepper u_chan_acw_stepper (.*);

  // entry: quarter, output, acw_in, expected acw, expected lane, flags {step,mon,eot,term,err}
  localparam int N = 15;
  localparam logic [80:0] VEC [N] = '{
    {1'b0,1'b0, 2'b00,1'b0,15'd5,18'h00100,   2'b00,1'b1,15'd5,18'h00100, 2'd0, 5'b00000}, // R1
    {1'b0,1'b1, 2'b00,1'b1,15'd5,18'h00100,   2'b00,1'b0,15'd4,18'h00101, 2'd1, 5'b10000}, // R2
    {1'b0,1'b0, 2'b10,1'b1,15'd3,18'h00100,   2'b10,1'b0,15'd2,18'h000FF, 2'd1, 5'b10000}, // R3
    {1'b0,1'b0, 2'b01,1'b1,15'd3,18'h00100,   2'b01,1'b0,15'd2,18'h00100, 2'd1, 5'b10000}, // R3
    {1'b0,1'b1, 2'b00,1'b1,15'd1,18'h3FFFF,   2'b00,1'b0,15'd0,18'h00000, 2'd1, 5'b11010}, // R6 R3
    {1'b0,1'b0, 2'b10,1'b1,15'd9,18'h00000,   2'b10,1'b0,15'd8,18'h3FFFF, 2'd1, 5'b10000}, // R3
    {1'b1,1'b0, 2'b00,2'b01,2'b00,12'd7,18'h20, 2'b00,2'b10,2'b00,12'd7,18'h20, 2'd1, 5'b00000}, // R4 R5
    {1'b1,1'b0, 2'b00,2'b11,2'b00,12'd7,18'h20, 2'b00,2'b00,2'b00,12'd6,18'h21, 2'd3, 5'b10000}, // R4 R12
    {1'b1,1'b1, 2'b00,2'b11,2'b01,12'd2,18'h20, 2'b00,2'b00,2'b01,12'd1,18'h21, 2'd3, 5'b11000}, // R7
    {1'b1,1'b1, 2'b00,2'b11,2'b10,12'd2,18'h20, 2'b00,2'b00,2'b10,12'd1,18'h21, 2'd3, 5'b10100}, // R8
    {1'b1,1'b0, 2'b00,2'b11,2'b11,12'd2,18'h20, 2'b00,2'b00,2'b11,12'd1,18'h21, 2'd3, 5'b10000}, // R9
    {1'b1,1'b1, 2'b11,2'b11,2'b11,12'd1,18'h20, 2'b11,2'b00,2'b11,12'd0,18'h20, 2'd3, 5'b11010}, // R6
    {1'b1,1'b1, 2'b00,2'b10,2'b11,12'd2,18'h20, 2'b00,2'b11,2'b11,12'd2,18'h20, 2'd2, 5'b00000}, // R7 R8 mid-word
    {1'b0,1'b1, 2'b00,1'b1,15'd0,18'h00055,   2'b00,1'b1,15'd0,18'h00055, 2'd1, 5'b00001}, // R10
    {1'b1,1'b1, 2'b00,2'b11,2'b11,12'd0,18'h7, 2'b00,2'b11,2'b11,12'd0,18'h7, 2'd3, 5'b00001}  // R10
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [80:0] v, input string req);
    @(negedge clk);
    quarter_mode = v[80]; is_output = v[79]; acw_in = v[78:43]; xfer_go = 1'b1;
    @(negedge clk);
    xfer_go = 1'b0;
    check({req, " acw"}, 64'(acw_out), 64'(v[42:7]));
    check({req, " lane R5"}, 64'(lane_sel), 64'(v[6:5]));
    check({req, " flags R12"}, 64'({word_step, mon_irq, eot_req, term_pulse, refuse_err}), 64'(v[4:0]));
    @(negedge clk);
    check("R11 pulses clear", 64'({word_step, mon_irq, eot_req, term_pulse, refuse_err}), 64'(0));
    check("R11 acw held", 64'(acw_out), 64'(v[42:7]));
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xfer_go = 1'b0; quarter_mode = 1'b0; is_output = 1'b0; acw_in = '0;
    repeat (3) @(negedge clk);
    check("R11 reset acw", 64'(acw_out), 64'(0));
    check("R11 reset flags", 64'({lane_sel, word_step, mon_irq, eot_req, term_pulse, refuse_err}), 64'(0));
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) run_vec(VEC[i], $sformatf("vec%0d", i));
    // R4: four quarter transfers walk one word, feeding the output back
    acw_in = {2'b00, 2'b00, 2'b00, 12'd3, 18'h40};
    quarter_mode = 1'b1; is_output = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); xfer_go = 1'b1;
      @(negedge clk); xfer_go = 1'b0;
      check("R4 walk lane", 64'(lane_sel), 64'(k));
      check("R12 walk step", 64'(word_step), 64'(k == 3));
      acw_in = acw_out;
    end
    check("R4 walk result", 64'(acw_out), 64'({2'b00, 2'b00, 2'b00, 12'd2, 18'h41}));
    // R11: back-to-back strobes with no idle cycle
    quarter_mode = 1'b0; acw_in = {2'b00, 1'b1, 15'd1, 18'h10};
    @(negedge clk); xfer_go = 1'b1;
    @(negedge clk);
    check("R6 back-to-back first", 64'({mon_irq, term_pulse}), 64'(3));
    acw_in = {2'b00, 1'b0, 15'd4, 18'h10};
    @(negedge clk); xfer_go = 1'b0;
    check("R11 back-to-back second", 64'({word_step, mon_irq, term_pulse}), 64'(0));
    check("R1 back-to-back acw", 64'(acw_out), 64'({2'b00, 1'b1, 15'd4, 18'h10}));
    // R11: reset mid-operation clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset again", 64'(acw_out), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule